// File: doc/BRIEF.md
# DMA Auto-Alignment Size Sequencer

This block plans the access sizes of a block transfer in a DMA channel. Software hands it a source address, a destination address, a byte count and a programmed access size for each side. With auto-alignment enabled, it picks one side to lead. The leading side's access size is chosen step by step, first from its address alignment and, near the end of the block, from the bytes still to move. The other side then uses the widest access that both its address and the step allow. Each step is offered on a valid/ready handshake together with a read size, a write size and a step length in bytes. The block advances its address and count registers when the step is accepted.

A start pulse loads a new configuration while the block is idle. The configuration is checked on the same edge. A bad configuration raises `cfg_err` and issues no steps. When auto-alignment is off, every step uses the programmed sizes and both sides are checked. Bus protocol and data buffering are handled elsewhere.

Top module: `aas_sequencer`

## Requirements
- R1: Size codes are 2'b00 longword (4 bytes), 2'b01 byte, 2'b10 word (2 bytes) and 2'b11 reserved. A reserved code on either side sets `cfg_err` one cycle after start, and no step is offered.
- R2: With auto-alignment on, the source leads when its size in bytes is at least the destination size in bytes. Otherwise the destination leads. `align_src` is 1 when the source leads.
- R3: Each accepted step moves the leading side's address up by the step length, whatever its increment bit says. A non-leading side moves only if its increment bit is 1.
- R4: While the count is 16 or more, the leading size is byte at an odd address and word at an address with bit 1 set (capped by the programmed size). Otherwise it is the programmed size. A count of exactly 16 follows this rule.
- R5: While the count is below 16, the leading size is the smaller of the programmed size and a count-based size. The count-based size is 4 if at least 4 bytes remain, 2 if at least 2 remain, and 1 otherwise.
- R6: The non-leading access size is the largest of 1, 2 and 4 bytes that meets three limits: it does not exceed that side's programmed size, it does not exceed the step length, and its address is aligned to it.
- R7: With auto-alignment on, an address that is misaligned to its programmed size sets `cfg_err` only when it is on the non-leading side. A misaligned leading address is accepted.
- R8: With auto-alignment off, every step moves the larger of the two sizes. The read size is the source code and the write size is the destination code. Either address being misaligned to its own size, or a count that is not a multiple of the step length, sets `cfg_err`.
- R9: Each accepted step lowers `bytes_left` by the step length, and no step exceeds `bytes_left`. `done` pulses for one cycle after the step that empties the count. A zero count gives `done` one cycle after start and no step.
- R10: A start pulse while `busy` is 1 is ignored.
- R11: While `step_valid` is 1 and `step_ready` is 0, the offered step and the registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load configuration (idle only) |
| cfg_align_en | input | 1 | Auto-alignment enable |
| cfg_src_addr | input | ADDR_W | Initial source address |
| cfg_dst_addr | input | ADDR_W | Initial destination address |
| cfg_count | input | CNT_W | Total bytes to move |
| cfg_src_size | input | 2 | Programmed source size code |
| cfg_dst_size | input | 2 | Programmed destination size code |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| step_ready | input | 1 | Consumer accepts the offered step |
| busy | output | 1 | Transfer in progress |
| step_valid | output | 1 | A step is offered |
| step_bytes | output | 3 | Bytes moved by the offered step (1, 2 or 4) |
| step_rd_size | output | 2 | Read access size code |
| step_wr_size | output | 2 | Write access size code |
| align_src | output | 1 | 1 when the source side leads |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| bytes_left | output | CNT_W | Bytes still to move |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| cfg_err | output | 1 | Configuration rejected at the last start |

## Verification
A wrong address or count register shows up at the ports within one step. The next offered size is wrong, and the end of the transfer, with its final addresses, falls on the wrong cycle. A wrong choice of leading side is visible on `align_src` in the first cycle after start, and it changes the very first offered sizes. The bench therefore checks the first two steps, the step count and the final addresses of each transfer. These cover both the address-driven phase and the count-driven tail.

// File: rtl/aas_pkg.sv
// Package: shared size codes and helpers for the auto-alignment sequencer.
// Assumes byte lengths are always 1, 2 or 4.
package aas_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_code_e;

    // Byte width of a size code (reserved maps to 1; it is rejected elsewhere).
    function automatic logic [2:0] code_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd4;
            2'b10:   return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // Size code for a byte width of 1, 2 or 4.
    function automatic logic [1:0] bytes_code(input logic [2:0] nbytes);
        case (nbytes)
            3'd4:    return SZ_LONG;
            3'd2:    return SZ_WORD;
            default: return SZ_BYTE;
        endcase
    endfunction

    // Widest access not above lim that the two low address bits allow.
    function automatic logic [2:0] fit_addr(input logic [1:0] lo, input logic [2:0] lim);
        if (lo[0])          return 3'd1;
        else if (lo[1])     return (lim >= 3'd2) ? 3'd2 : 3'd1;
        else                return lim;
    endfunction

    // Smaller of two byte widths.
    function automatic logic [2:0] min_b(input logic [2:0] a, input logic [2:0] b);
        return (a < b) ? a : b;
    endfunction

    // True when the low address bits are not aligned to the byte width.
    function automatic logic misaligned(input logic [1:0] lo, input logic [2:0] nbytes);
        return ((nbytes == 3'd4) && (lo != 2'b00)) || ((nbytes == 3'd2) && lo[0]);
    endfunction

endpackage

// File: rtl/aas_side_select.sv
// Leading-side choice: the source leads when its size is at least the
// destination size, else the destination leads. Assumes codes are not reserved
// (reserved codes are rejected by the checker; their value here is harmless).
module aas_side_select
    import aas_pkg::*;
(
    input  logic [1:0] src_size,
    input  logic [1:0] dst_size,
    output logic       src_leads
);

    // Compare byte widths; ties go to the source.
    always_comb begin
        src_leads = (code_bytes(src_size) >= code_bytes(dst_size));
    end

endmodule

// File: rtl/aas_cfg_check.sv
// Configuration checker evaluated on the start configuration.
// With auto-alignment on, only the non-leading side's address is checked;
// with it off, both addresses and the count are checked against the sizes.
module aas_cfg_check
    import aas_pkg::*;
(
    input  logic       align_en,
    input  logic       src_leads,
    input  logic [1:0] src_lo,
    input  logic [1:0] dst_lo,
    input  logic [1:0] cnt_lo,
    input  logic [1:0] src_size,
    input  logic [1:0] dst_size,
    output logic       err
);

    logic [2:0] src_b;
    logic [2:0] dst_b;
    logic [2:0] big_b;
    logic       rsvd;

    // Derive widths and the reserved-code flag.
    always_comb begin
        src_b = code_bytes(src_size);
        dst_b = code_bytes(dst_size);
        big_b = (src_b > dst_b) ? src_b : dst_b;
        rsvd  = (src_size == SZ_RSVD) || (dst_size == SZ_RSVD);
    end

    // Combine the per-mode checks into one error flag.
    always_comb begin
        if (align_en) begin
            err = rsvd || (src_leads ? misaligned(dst_lo, dst_b)
                                     : misaligned(src_lo, src_b));
        end else begin
            err = rsvd || misaligned(src_lo, src_b) || misaligned(dst_lo, dst_b)
                       || misaligned(cnt_lo, big_b);
        end
    end

endmodule

// File: rtl/aas_size_picker.sv
// Per-step size selection from the current registers. The leading size
// follows the address while at least 16 bytes remain and the count below
// that; the other side takes the widest access its address and the step allow.
// Assumes the configuration has passed the checker.
module aas_size_picker
    import aas_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             align_en,
    input  logic             src_leads,
    input  logic [1:0]       src_lo,
    input  logic [1:0]       dst_lo,
    input  logic [1:0]       src_size,
    input  logic [1:0]       dst_size,
    input  logic [CNT_W-1:0] count,
    output logic [2:0]       step_len,
    output logic [1:0]       rd_code,
    output logic [1:0]       wr_code
);

    localparam logic [CNT_W-1:0] ADDR_RULE_MIN = CNT_W'(16);
    localparam logic [CNT_W-1:0] CNT_FOUR      = CNT_W'(4);
    localparam logic [CNT_W-1:0] CNT_TWO       = CNT_W'(2);

    logic [2:0] src_b, dst_b;
    logic [2:0] lead_lim, trail_lim;
    logic [1:0] lead_lo, trail_lo;
    logic [2:0] cnt_b, lead_b, trail_b;

    // Route the leading and trailing side attributes.
    always_comb begin
        src_b     = code_bytes(src_size);
        dst_b     = code_bytes(dst_size);
        lead_lim  = src_leads ? src_b  : dst_b;
        trail_lim = src_leads ? dst_b  : src_b;
        lead_lo   = src_leads ? src_lo : dst_lo;
        trail_lo  = src_leads ? dst_lo : src_lo;
    end

    // Count-based width used for the tail of the block.
    always_comb begin
        if (count >= CNT_FOUR)     cnt_b = 3'd4;
        else if (count >= CNT_TWO) cnt_b = 3'd2;
        else                       cnt_b = 3'd1;
    end

    // Leading width: address rule at 16 bytes and above, count rule below.
    always_comb begin
        if (count >= ADDR_RULE_MIN) lead_b = fit_addr(lead_lo, lead_lim);
        else                        lead_b = min_b(cnt_b, lead_lim);
        trail_b = fit_addr(trail_lo, min_b(trail_lim, lead_b));
    end

    // Produce the step length and the read and write codes for the mode.
    always_comb begin
        if (!align_en) begin
            step_len = (src_b > dst_b) ? src_b : dst_b;
            rd_code  = src_size;
            wr_code  = dst_size;
        end else begin
            step_len = lead_b;
            rd_code  = src_leads ? bytes_code(lead_b)  : bytes_code(trail_b);
            wr_code  = src_leads ? bytes_code(trail_b) : bytes_code(lead_b);
        end
    end

endmodule

// File: rtl/aas_sequencer.sv
// Top of the auto-alignment size sequencer. Loads a configuration on start
// while idle, offers one sized step per cycle on a valid/ready handshake and
// advances the address and count registers on each accepted step.
// Assumes CNT_W >= 5 so that the 16-byte threshold is representable.
module aas_sequencer
    import aas_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_align_en,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [1:0]        cfg_src_size,
    input  logic [1:0]        cfg_dst_size,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic              step_ready,
    output logic              busy,
    output logic              step_valid,
    output logic [2:0]        step_bytes,
    output logic [1:0]        step_rd_size,
    output logic [1:0]        step_wr_size,
    output logic              align_src,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [CNT_W-1:0]  bytes_left,
    output logic              done,
    output logic              cfg_err
);

    logic              busy_q, done_q, err_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        ssz_q, dsz_q;
    logic              sinc_q, dinc_q, aen_q;

    logic              lead_src_q;   // leading side of the loaded configuration
    logic              lead_src_in;  // leading side of the start configuration
    logic              chk_err;
    logic [2:0]        len;
    logic              accept;
    logic              src_move, dst_move;

    aas_side_select u_side_now (
        .src_size  (ssz_q),
        .dst_size  (dsz_q),
        .src_leads (lead_src_q)
    );

    aas_side_select u_side_cfg (
        .src_size  (cfg_src_size),
        .dst_size  (cfg_dst_size),
        .src_leads (lead_src_in)
    );

    aas_cfg_check u_check (
        .align_en  (cfg_align_en),
        .src_leads (lead_src_in),
        .src_lo    (cfg_src_addr[1:0]),
        .dst_lo    (cfg_dst_addr[1:0]),
        .cnt_lo    (cfg_count[1:0]),
        .src_size  (cfg_src_size),
        .dst_size  (cfg_dst_size),
        .err       (chk_err)
    );

    aas_size_picker #(.CNT_W(CNT_W)) u_pick (
        .align_en  (aen_q),
        .src_leads (lead_src_q),
        .src_lo    (src_q[1:0]),
        .dst_lo    (dst_q[1:0]),
        .src_size  (ssz_q),
        .dst_size  (dsz_q),
        .count     (cnt_q),
        .step_len  (len),
        .rd_code   (step_rd_size),
        .wr_code   (step_wr_size)
    );

    // Handshake and per-side advance enables (leading side always moves).
    always_comb begin
        accept   = busy_q && step_ready;
        src_move = sinc_q || (aen_q && lead_src_q);
        dst_move = dinc_q || (aen_q && !lead_src_q);
    end

    // Configuration load, step advance and end-of-transfer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            ssz_q  <= SZ_BYTE;
            dsz_q  <= SZ_BYTE;
            sinc_q <= 1'b0;
            dinc_q <= 1'b0;
            aen_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start) begin
                src_q  <= cfg_src_addr;
                dst_q  <= cfg_dst_addr;
                cnt_q  <= cfg_count;
                ssz_q  <= cfg_src_size;
                dsz_q  <= cfg_dst_size;
                sinc_q <= cfg_src_inc;
                dinc_q <= cfg_dst_inc;
                aen_q  <= cfg_align_en;
                err_q  <= chk_err;
                busy_q <= !chk_err && (cfg_count != '0);
                done_q <= !chk_err && (cfg_count == '0);
            end else if (accept) begin
                if (src_move) src_q <= src_q + ADDR_W'(len);
                if (dst_move) dst_q <= dst_q + ADDR_W'(len);
                cnt_q <= cnt_q - CNT_W'(len);
                if (cnt_q == CNT_W'(len)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        busy       = busy_q;
        step_valid = busy_q;
        step_bytes = len;
        align_src  = lead_src_q;
        src_addr   = src_q;
        dst_addr   = dst_q;
        bytes_left = cnt_q;
        done       = done_q;
        cfg_err    = err_q;
    end

    // ---------------------------------------------------------------- checks
    assert_step_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (step_bytes != 3'd0) && (CNT_W'(step_bytes) <= bytes_left))
        else $error("step longer than remaining count");

    assert_count_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_ready) |=> bytes_left == $past(bytes_left) - CNT_W'($past(step_bytes)))
        else $error("count did not drop by the step length");

    assert_lead_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_ready && aen_q && align_src)
        |=> src_addr == $past(src_addr) + ADDR_W'($past(step_bytes)))
        else $error("leading source address did not advance");

    assert_err_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !step_valid)
        else $error("step offered after a configuration error");

    assert_no_rsvd_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (step_rd_size != SZ_RSVD) && (step_wr_size != SZ_RSVD))
        else $error("reserved size code offered");

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_ready) |=> step_valid && $stable(bytes_left) && $stable(step_bytes)
                                        && $stable(src_addr) && $stable(dst_addr))
        else $error("stalled step changed");

endmodule

// File: tb/test_aas_sequencer.sv
module test_aas_sequencer;

    localparam int AW = 16;
    localparam int CW = 16;

    typedef struct packed {
        logic [15:0] sa, da, cnt;
        logic [1:0]  ss, ds;
        logic        si, di, aen;
        logic [1:0]  e_rd, e_wr;
        logic [2:0]  e_len;
        logic        e_lead;
        logic [15:0] e_steps, e_sa, e_da;
    } vec_t;

    // Codes: 00 long, 01 byte, 10 word.
    localparam vec_t VECS [5] = '{
        '{16'h0001, 16'h1000, 16'h00F0, 2'b00, 2'b01, 1'b1, 1'b1, 1'b1,
          2'b01, 2'b01, 3'd1, 1'b1, 16'd62, 16'h00F1, 16'h10F0},
        '{16'h2000, 16'h0003, 16'h0020, 2'b01, 2'b00, 1'b1, 1'b1, 1'b1,
          2'b01, 2'b01, 3'd1, 1'b0, 16'd10, 16'h2020, 16'h0023},
        '{16'h0100, 16'h0200, 16'h0010, 2'b10, 2'b00, 1'b1, 1'b1, 1'b0,
          2'b10, 2'b00, 3'd4, 1'b0, 16'd4,  16'h0110, 16'h0210},
        '{16'h0005, 16'h0040, 16'h0012, 2'b10, 2'b10, 1'b1, 1'b1, 1'b1,
          2'b01, 2'b01, 3'd1, 1'b1, 16'd10, 16'h0017, 16'h0052},
        '{16'h0010, 16'h3000, 16'h0020, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1,
          2'b00, 2'b10, 3'd4, 1'b1, 16'd8,  16'h0030, 16'h3000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_align_en = 1'b0;
    logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [1:0] cfg_src_size = 2'b01, cfg_dst_size = 2'b01;
    logic cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
    logic step_ready = 1'b1;
    logic busy, step_valid, align_src, done, cfg_err;
    logic [2:0] step_bytes;
    logic [1:0] step_rd_size, step_wr_size;
    logic [AW-1:0] src_addr, dst_addr;
    logic [CW-1:0] bytes_left;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    aas_sequencer #(.ADDR_W(AW), .CNT_W(CW)) i_aas_sequencer (
        .clk, .rst_n, .start, .cfg_align_en, .cfg_src_addr, .cfg_dst_addr,
        .cfg_count, .cfg_src_size, .cfg_dst_size, .cfg_src_inc, .cfg_dst_inc,
        .step_ready, .busy, .step_valid, .step_bytes, .step_rd_size,
        .step_wr_size, .align_src, .src_addr, .dst_addr, .bytes_left,
        .done, .cfg_err
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a configuration and a one-cycle start; returns at the first negedge after load.
    task automatic kick(input logic [15:0] sa, input logic [15:0] da, input logic [15:0] cnt,
                        input logic [1:0] ss, input logic [1:0] ds,
                        input logic si, input logic di, input logic aen);
        @(negedge clk);
        cfg_src_addr = sa; cfg_dst_addr = da; cfg_count = cnt;
        cfg_src_size = ss; cfg_dst_size = ds;
        cfg_src_inc = si; cfg_dst_inc = di; cfg_align_en = aen;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Accept steps until done; reports first two steps and the step count.
    task automatic run_out(output int steps, output logic [2:0] len0, output logic [1:0] rd0,
                           output logic [1:0] wr0, output logic [2:0] len1, output logic saw_done);
        steps = 0; len0 = '0; rd0 = '0; wr0 = '0; len1 = '0; saw_done = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (done) begin
                saw_done = 1'b1;
                break;
            end
            if (step_valid && step_ready) begin
                if (steps == 0) begin len0 = step_bytes; rd0 = step_rd_size; wr0 = step_wr_size; end
                if (steps == 1) len1 = step_bytes;
                steps++;
            end
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL R9: watchdog actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int steps;
        logic [2:0] len0, len1;
        logic [1:0] rd0, wr0;
        logic sd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R9 reset busy", {31'd0, busy}, 32'd0);
        check("R9 reset done", {31'd0, done}, 32'd0);
        check("R7 reset err", {31'd0, cfg_err}, 32'd0);
        check("R9 reset count", {16'd0, bytes_left}, 32'd0);

        // Vector table
        for (int v = 0; v < 5; v++) begin
            kick(VECS[v].sa, VECS[v].da, VECS[v].cnt, VECS[v].ss, VECS[v].ds,
                 VECS[v].si, VECS[v].di, VECS[v].aen);
            check("R7 R8 no error", {31'd0, cfg_err}, 32'd0);
            if (VECS[v].aen)
                check("R2 leading side", {31'd0, align_src}, {31'd0, VECS[v].e_lead});
            run_out(steps, len0, rd0, wr0, len1, sd);
            check("R4 R8 first length", {29'd0, len0}, {29'd0, VECS[v].e_len});
            check("R6 R8 first read code", {30'd0, rd0}, {30'd0, VECS[v].e_rd});
            check("R6 R8 first write code", {30'd0, wr0}, {30'd0, VECS[v].e_wr});
            check("R5 R9 step count", steps, {16'd0, VECS[v].e_steps});
            check("R9 done seen", {31'd0, sd}, 32'd1);
            check("R3 final source", {16'd0, src_addr}, {16'd0, VECS[v].e_sa});
            check("R3 final destination", {16'd0, dst_addr}, {16'd0, VECS[v].e_da});
            check("R9 count empty", {16'd0, bytes_left}, 32'd0);
        end

        // R1: reserved source code rejected
        kick(16'h0000, 16'h0000, 16'h0008, 2'b11, 2'b01, 1'b1, 1'b1, 1'b1);
        check("R1 reserved code error", {31'd0, cfg_err}, 32'd1);
        check("R1 no step", {31'd0, step_valid}, 32'd0);

        // R7: misaligned destination on the non-leading side
        kick(16'h0000, 16'h0001, 16'h0020, 2'b00, 2'b10, 1'b1, 1'b1, 1'b1);
        check("R7 trailing misalign error", {31'd0, cfg_err}, 32'd1);
        check("R7 no step", {31'd0, busy}, 32'd0);

        // R8: count not a multiple of the step with alignment off
        kick(16'h0000, 16'h0000, 16'h0006, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
        check("R8 count multiple error", {31'd0, cfg_err}, 32'd1);

        // R4: count of exactly 16 uses the address rule
        kick(16'h0002, 16'h0100, 16'h0010, 2'b00, 2'b01, 1'b1, 1'b1, 1'b1);
        run_out(steps, len0, rd0, wr0, len1, sd);
        check("R4 count 16 first length", {29'd0, len0}, 32'd2);
        check("R4 count 16 second length", {29'd0, len1}, 32'd4);

        // R5: tail size capped by the programmed word size
        kick(16'h0000, 16'h0100, 16'h0005, 2'b10, 2'b01, 1'b1, 1'b1, 1'b1);
        run_out(steps, len0, rd0, wr0, len1, sd);
        check("R5 capped first length", {29'd0, len0}, 32'd2);
        check("R5 capped step count", steps, 32'd3);

        // R9: zero count
        kick(16'h0000, 16'h0000, 16'h0000, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
        check("R9 zero count done", {31'd0, done}, 32'd1);
        check("R9 zero count no step", {31'd0, step_valid}, 32'd0);

        // R11 and R10: stall, then a start while busy
        step_ready = 1'b0;
        kick(16'h0010, 16'h3000, 16'h0020, 2'b00, 2'b10, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R11 stalled valid", {31'd0, step_valid}, 32'd1);
        check("R11 stalled count", {16'd0, bytes_left}, 32'h20);
        check("R11 stalled source", {16'd0, src_addr}, 32'h10);
        kick(16'h0000, 16'h0000, 16'h0004, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0);
        check("R10 start ignored count", {16'd0, bytes_left}, 32'h20);
        check("R10 start ignored source", {16'd0, src_addr}, 32'h10);
        check("R10 start ignored length", {29'd0, step_bytes}, 32'd4);
        step_ready = 1'b1;
        run_out(steps, len0, rd0, wr0, len1, sd);
        check("R10 original run steps", steps, 32'd8);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule